// File: doc/BRIEF.md
# SDRAM Refresh and Power-State Sequencer

This block sits on the controller side of a two-bank SDR SDRAM. It owns the command pins and the clock-enable pin whenever the memory has to be refreshed or put into a low-power state. The read/write scheduler hands over control through three request inputs: a periodic refresh pulse, a level self-refresh request and a level power-down request. It also reports which banks it has left open. While this block works, it raises `busy` and the scheduler keeps off the bus.

An auto refresh closes any open bank with a precharge-all, waits out the precharge time and issues one refresh. It then holds the bus quiet for the refresh cycle time and pulses `ack`. A self-refresh request first issues a full burst of refreshes. It then drops CKE together with a final refresh and holds CKE low until the request falls. After that it waits out the refresh cycle time and issues a second burst before it acknowledges. A power-down request lowers CKE. The flavour, clock suspend or precharge power-down, follows from the bank state at entry. A refresh that arrives during power-down wakes the device, runs the refresh and lets the power-down resume.

None of the pins carries a data stream, so every port is a plain level or pulse and there is no back-pressure. The timing limits are parameters in clock cycles: `T_RP` of at least 2, `T_RFC` of at least 2, `T_SS` of at least 1, and `REF_BURST` refreshes per burst. Requests are served in priority order: self refresh first, then a pending refresh, then power-down.

Top module: `sdram_pwr_seq`

## Requirements
- R1: A refresh is never issued while the last reported bank state has an open bank. If a sequence starts with any bank open, a precharge-all comes first, and the first refresh follows it by at least T_RP cycles.
- R2: After a refresh issued with CKE high, no command appears on the bus for T_RFC cycles. An auto refresh request produces exactly one refresh before its acknowledge.
- R3: Self refresh is entered by a refresh issued in the same cycle that CKE goes low. CKE stays low for as long as `sr_req` stays high.
- R4: While in self refresh, the bus shows NOP and CKE stays low whatever `bank_open`, `ref_req` and `pd_req` do. A `ref_req` pulse given there is discarded and causes no later refresh.
- R5: After CKE rises to leave self refresh, no command is issued for T_RFC cycles.
- R6: Exactly REF_BURST refreshes with CKE high come between the start of a self-refresh sequence and the entry refresh. Exactly REF_BURST more come between the exit and the acknowledge.
- R7: While in power-down (CKE low, not self refresh), `pd_clock_suspend` is 1 if any bank was open at entry and 0 if all banks were closed.
- R8: After CKE rises to leave power-down, no command is issued for at least T_SS cycles.
- R9: A refresh request during power-down raises CKE and runs the refresh to its acknowledge. If `pd_req` is still high, CKE goes low again afterwards.
- R10: The command is driven on {cs_n, ras_n, cas_n, we_n}. NOP is 0111, precharge is 0010 with `a10` high (all banks), refresh is 0001. No other code appears.
- R11: `busy` is low only when the bus is NOP with CKE high. `ack` is a single-cycle pulse with `busy` low, given T_RFC cycles after the last refresh of the sequence.
- R12: During and right after reset, CKE is high, the bus shows NOP, and `busy` and `ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | input | 1 | Periodic refresh request pulse |
| sr_req | input | 1 | Self-refresh request level |
| pd_req | input | 1 | Power-down request level |
| bank_open | input | NUM_BANKS | Per-bank open flags from the scheduler |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, high for precharge-all |
| cke | output | 1 | Clock enable to the device |
| busy | output | 1 | Sequencer owns the bus |
| ack | output | 1 | One-cycle completion pulse of a refresh or self-refresh sequence |
| pd_clock_suspend | output | 1 | High during power-down entered with a bank open |

## Verification
The hardest state to reach is the one where inputs change while the device sits in self refresh. It only exists after a full entry burst with CKE low. The bench holds `sr_req` until it sees CKE fall. It then swaps the bank flags for random noise and pulses the refresh and power-down inputs. Only after that does it drop the request, and it counts the refreshes that follow the exit acknowledge. A second hard case is a refresh arriving inside power-down with banks open, which the bench sets up directly and also reaches through random request toggling.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_TRP, ST_REF, ST_TRFC,
    ST_SR_IN, ST_SR, ST_SR_OUT, ST_PD, ST_PD_OUT
  } seq_state_e;

  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_REF} cmd_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_NOP = 4'b0111;
  localparam logic [3:0] PINS_PRE = 4'b0010;
  localparam logic [3:0] PINS_REF = 4'b0001;

endpackage

// File: rtl/pwr_down_cnt.sv
module pwr_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] init,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= init;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwr_cmd_enc.sv
module pwr_cmd_enc
  import sdram_pwr_pkg::*;
(
  input  cmd_e       cmd,
  output logic [3:0] pins,
  output logic       a10
);
  always_comb begin
    unique case (cmd)
      CMD_PRE: begin pins = PINS_PRE; a10 = 1'b1; end
      CMD_REF: begin pins = PINS_REF; a10 = 1'b0; end
      default: begin pins = PINS_NOP; a10 = 1'b0; end
    endcase
  end
endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdram_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 7,
  parameter int T_SS      = 1,
  parameter int REF_BURST = 2048
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_req,
  input  logic                 sr_req,
  input  logic                 pd_req,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic                 a10,
  output logic                 cke,
  output logic                 busy,
  output logic                 ack,
  output logic                 pd_clock_suspend
);
  localparam int RP_W  = $clog2(T_RP + 1);
  localparam int RFC_W = $clog2(T_RFC + 1);
  localparam int SS_W  = $clog2(T_SS + 1);
  localparam int BST_W = $clog2(REF_BURST + 1);
  localparam logic [RP_W-1:0]  RP_INIT   = RP_W'(T_RP - 2);
  localparam logic [RFC_W-1:0] RFC_LOCK  = RFC_W'(T_RFC - 2);
  localparam logic [RFC_W-1:0] RFC_WAKE  = RFC_W'(T_RFC - 1);
  localparam logic [SS_W-1:0]  SS_INIT   = SS_W'(T_SS - 1);
  localparam logic [BST_W-1:0] BST_INIT  = BST_W'(REF_BURST - 1);

  seq_state_e state_q, state_d;
  logic mode_sr_q, mode_sr_d;   // sequence belongs to self refresh
  logic exit_q, exit_d;         // self-refresh exit burst in progress
  logic susp_q, susp_d;         // power-down entered with a bank open
  logic pend_q, pend_d;         // refresh request waiting
  logic ack_q, ack_d;

  logic rp_ld, rp_dec, rp_zero;
  logic rfc_ld, rfc_dec, rfc_zero;
  logic ss_ld, ss_dec, ss_zero;
  logic bst_ld, bst_dec, bst_zero;
  logic [RFC_W-1:0] rfc_init;
  logic [BST_W-1:0] bst_init;

  logic any_open, start_go, do_start, in_sr;
  cmd_e cmd;
  logic [3:0] pins;

  assign any_open = |bank_open;
  assign start_go = sr_req | pend_q;
  assign in_sr    = (state_q == ST_SR_IN) || (state_q == ST_SR);

  always_comb begin
    state_d   = state_q;
    mode_sr_d = mode_sr_q;
    exit_d    = exit_q;
    susp_d    = susp_q;
    ack_d     = 1'b0;
    do_start  = 1'b0;
    rp_ld = 1'b0;  rp_dec = 1'b0;
    rfc_ld = 1'b0; rfc_dec = 1'b0; rfc_init = RFC_LOCK;
    ss_ld = 1'b0;  ss_dec = 1'b0;
    bst_ld = 1'b0; bst_dec = 1'b0; bst_init = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_go) do_start = 1'b1;
        else if (pd_req) begin
          state_d = ST_PD;
          susp_d  = any_open;
        end
      end
      ST_PRE: begin
        state_d = ST_TRP;
        rp_ld   = 1'b1;
      end
      ST_TRP: begin
        if (rp_zero) state_d = ST_REF;
        else         rp_dec  = 1'b1;
      end
      ST_REF: begin
        state_d = ST_TRFC;
        rfc_ld  = 1'b1;
      end
      ST_TRFC: begin
        if (!rfc_zero) rfc_dec = 1'b1;
        else if (!bst_zero) begin
          bst_dec = 1'b1;
          state_d = ST_REF;
        end else if (mode_sr_q && !exit_q) state_d = ST_SR_IN;
        else begin
          state_d = ST_IDLE;
          ack_d   = 1'b1;
        end
      end
      ST_SR_IN: state_d = ST_SR;
      ST_SR: begin
        if (!sr_req) begin
          state_d  = ST_SR_OUT;
          rfc_ld   = 1'b1;
          rfc_init = RFC_WAKE;
        end
      end
      ST_SR_OUT: begin
        if (!rfc_zero) rfc_dec = 1'b1;
        else begin
          exit_d   = 1'b1;
          bst_ld   = 1'b1;
          bst_init = BST_INIT;
          state_d  = ST_REF;
        end
      end
      ST_PD: begin
        if (start_go || !pd_req) begin
          state_d = ST_PD_OUT;
          ss_ld   = 1'b1;
        end
      end
      ST_PD_OUT: begin
        if (!ss_zero)      ss_dec   = 1'b1;
        else if (start_go) do_start = 1'b1;
        else               state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (do_start) begin
      mode_sr_d = sr_req;
      exit_d    = 1'b0;
      bst_ld    = 1'b1;
      bst_init  = sr_req ? BST_INIT : '0;
      state_d   = any_open ? ST_PRE : ST_REF;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:           cmd = CMD_PRE;
      ST_REF, ST_SR_IN: cmd = CMD_REF;
      default:          cmd = CMD_NOP;
    endcase
  end

  // any refresh satisfies a waiting request; requests in self refresh are dropped
  assign pend_d = (pend_q | (ref_req & ~in_sr)) & (cmd != CMD_REF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_sr_q <= 1'b0;
      exit_q    <= 1'b0;
      susp_q    <= 1'b0;
      pend_q    <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      mode_sr_q <= mode_sr_d;
      exit_q    <= exit_d;
      susp_q    <= susp_d;
      pend_q    <= pend_d;
      ack_q     <= ack_d;
    end
  end

  pwr_down_cnt #(.W(RP_W)) u_rp_cnt (
    .clk(clk), .rst_n(rst_n), .load(rp_ld), .dec(rp_dec), .init(RP_INIT), .zero(rp_zero));
  pwr_down_cnt #(.W(RFC_W)) u_rfc_cnt (
    .clk(clk), .rst_n(rst_n), .load(rfc_ld), .dec(rfc_dec), .init(rfc_init), .zero(rfc_zero));
  pwr_down_cnt #(.W(SS_W)) u_ss_cnt (
    .clk(clk), .rst_n(rst_n), .load(ss_ld), .dec(ss_dec), .init(SS_INIT), .zero(ss_zero));
  pwr_down_cnt #(.W(BST_W)) u_bst_cnt (
    .clk(clk), .rst_n(rst_n), .load(bst_ld), .dec(bst_dec), .init(bst_init), .zero(bst_zero));

  pwr_cmd_enc u_enc (.cmd(cmd), .pins(pins), .a10(a10));

  assign {cs_n, ras_n, cas_n, we_n} = pins;
  assign cke  = !((state_q == ST_SR_IN) || (state_q == ST_SR) || (state_q == ST_PD));
  assign busy = (state_q != ST_IDLE);
  assign ack  = ack_q;
  assign pd_clock_suspend = (state_q == ST_PD) && susp_q;

endmodule

// File: rtl/sdram_pwr_seq_chk.sv
module sdram_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10,
  input logic cke,
  input logic busy,
  input logic ack
);
  logic started;
  logic is_nop, is_pre, is_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
  assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
  assign is_ref = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);

  AST_PRE_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> is_nop); // R1
  AST_REF_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && cke) |=> is_nop); // R2
  AST_SR_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && !cke) |=> !cke); // R3
  AST_LOW_CKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !cke && !$past(cke)) |-> is_nop); // R4
  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $rose(cke)) |-> is_nop); // R8
  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nop || is_pre || is_ref)); // R10
  AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> a10); // R10
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!busy && is_nop && cke)); // R11
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (is_nop && cke)); // R11
endmodule

bind sdram_pwr_seq sdram_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .a10(a10), .cke(cke), .busy(busy), .ack(ack));

// File: tb/tb_sdram_pwr_seq.sv
module tb_sdram_pwr_seq;
  localparam int T_RP  = 3;
  localparam int T_RFC = 5;
  localparam int T_SS  = 2;
  localparam int BURST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_req = 1'b0, sr_req = 1'b0, pd_req = 1'b0;
  logic [1:0] bank_open;
  logic cs_n, ras_n, cas_n, we_n, a10, cke, busy, ack, pd_clock_suspend;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // scheduler model: stimulus posts a bank state, monitor applies it and clears on precharge
  logic [1:0] banks_req = '0, model_open = '0, noise_val = '0;
  int banks_wr = 0, banks_seen = 0;
  bit noise = 1'b0;
  assign bank_open = noise ? noise_val : model_open;

  sdram_pwr_seq #(.NUM_BANKS(2), .T_RP(T_RP), .T_RFC(T_RFC), .T_SS(T_SS), .REF_BURST(BURST)) dut (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .sr_req(sr_req), .pd_req(pd_req),
    .bank_open(bank_open), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .a10(a10), .cke(cke), .busy(busy), .ack(ack), .pd_clock_suspend(pd_clock_suspend));

  always #5 clk = ~clk;

  function automatic logic [3:0] f_enc(input int k);
    case (k)
      1:       return 4'b0010;
      2:       return 4'b0001;
      default: return 4'b0111;
    endcase
  endfunction
  function automatic int f_ack_refs(input bit after_sr);
    return after_sr ? BURST : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_banks(input logic [1:0] v);
    banks_req = v; banks_wr++;
    tick();
  endtask

  task automatic wait_ack(input int lim, output bit got);
    got = 1'b0;
    for (int i = 0; i < lim && !got; i++) begin tick(); if (ack) got = 1'b1; end
  endtask

  task automatic wait_cke(input logic v, input int lim, output bit got);
    got = (cke == v);
    for (int i = 0; i < lim && !got; i++) begin tick(); if (cke == v) got = 1'b1; end
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && busy; i++) tick();
  endtask

  // ---------------- protocol monitor ----------------
  logic [3:0] cmd;
  int cyc = 0, last_pre = -1000, last_ref = -1000, rise_cyc = 0, rise_gap = 0, ref_cnt = 0;
  string rise_tag = "";
  bit in_sr = 0, sr_exit = 0, prev_ack = 0, prev_cke = 1, sr_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      cmd = {cs_n, ras_n, cas_n, we_n};
      if (in_sr && sr_prev) chk(!cke, "R3 cke held low in self refresh", cke, 0);
      if (in_sr && !cke) chk(cmd == f_enc(0), "R4 bus quiet in self refresh", cmd, f_enc(0));
      if (cmd != f_enc(0)) begin
        chk(cmd == f_enc(1) || cmd == f_enc(2), "R10 legal command code", cmd, f_enc(2));
        chk(busy, "R11 busy while commanding", busy, 1);
        if (rise_gap > 0) begin
          chk(cyc - rise_cyc >= rise_gap, rise_tag, cyc - rise_cyc, rise_gap);
          rise_gap = 0;
        end
        chk(cyc - last_ref >= T_RFC, "R2 lockout after refresh", cyc - last_ref, T_RFC);
      end
      if (cmd == f_enc(1)) begin
        chk(a10, "R10 precharge-all a10", a10, 1);
        last_pre = cyc;
      end
      if (cmd == f_enc(2)) begin
        chk(model_open == 0, "R1 banks closed at refresh", model_open, 0);
        chk(cyc - last_pre >= T_RP, "R1 precharge to refresh gap", cyc - last_pre, T_RP);
        if (cke) ref_cnt++;
        else begin
          chk(ref_cnt == BURST, "R6 burst before self refresh", ref_cnt, BURST);
          ref_cnt = 0;
        end
        last_ref = cyc;
      end
      if (prev_cke && !cke && cmd != f_enc(2))
        chk(pd_clock_suspend == (model_open != 0), "R7 power-down flavour",
            pd_clock_suspend, model_open != 0);
      if (!prev_cke && cke) begin
        rise_cyc = cyc;
        if (in_sr) begin
          rise_gap = T_RFC; rise_tag = "R5 quiet after self-refresh exit";
          in_sr = 0; sr_exit = 1;
        end else begin
          rise_gap = T_SS; rise_tag = "R8 CKE setup after power-down exit";
        end
      end
      if (cmd == f_enc(2) && !cke) in_sr = 1;
      if (ack) begin
        chk(!busy, "R11 ack with busy low", busy, 0);
        chk(!prev_ack, "R11 ack single cycle", prev_ack, 0);
        chk(cyc - last_ref == T_RFC, "R11 ack after final lockout", cyc - last_ref, T_RFC);
        chk(ref_cnt == f_ack_refs(sr_exit), sr_exit ? "R6 burst after self refresh" :
            "R2 one refresh per request", ref_cnt, f_ack_refs(sr_exit));
        ref_cnt = 0; sr_exit = 0;
      end
      if (cmd == f_enc(1)) model_open = '0;
      else if (banks_wr != banks_seen) begin model_open = banks_req; banks_seen = banks_wr; end
      prev_ack = ack; prev_cke = cke; sr_prev = sr_req;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG run timeout", 0, 1);
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    bit got;
    int n, refs;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    chk(cke && {cs_n, ras_n, cas_n, we_n} == f_enc(0), "R12 idle bus in reset", cke, 1);
    chk(!busy && !ack, "R12 busy/ack low in reset", busy, 0);
    rst_n = 1'b1;
    tick();
    chk(cke && {cs_n, ras_n, cas_n, we_n} == f_enc(0) && !busy && !ack,
        "R12 state after reset", busy, 0);

    // R1: auto refresh with both banks open
    set_banks(2'b11);
    ref_req = 1; tick(); ref_req = 0;
    wait_ack(100, got);
    chk(got, "R1 refresh with open banks completes", got, 1);

    // R2: auto refresh with banks closed
    tick();
    ref_req = 1; tick(); ref_req = 0;
    wait_ack(100, got);
    chk(got, "R2 refresh with closed banks completes", got, 1);

    // R7: precharge power-down
    pd_req = 1;
    wait_cke(0, 20, got);
    chk(got && !pd_clock_suspend, "R7 precharge power-down", pd_clock_suspend, 0);
    repeat (4) tick();
    pd_req = 0;
    wait_idle(20);
    chk(!busy && cke, "R8 power-down exit returns to idle", busy, 0);

    // R7: active power-down
    set_banks(2'b01);
    pd_req = 1;
    wait_cke(0, 20, got);
    chk(got && pd_clock_suspend, "R7 clock-suspend power-down", pd_clock_suspend, 1);
    repeat (3) tick();
    pd_req = 0;
    wait_idle(20);

    // R9: refresh arriving inside power-down
    set_banks(2'b10);
    pd_req = 1;
    wait_cke(0, 20, got);
    repeat (4) tick();
    ref_req = 1; tick(); ref_req = 0;
    wait_cke(1, 4, got);
    chk(got, "R9 wake from power-down on refresh", cke, 1);
    wait_ack(100, got);
    chk(got, "R9 refresh acknowledged", got, 1);
    wait_cke(0, 5, got);
    chk(got && !pd_clock_suspend, "R9 power-down resumes", cke, 0);
    pd_req = 0;
    wait_idle(20);

    // R4/R6: self refresh with noisy inputs
    set_banks(2'b11);
    sr_req = 1;
    wait_cke(0, 500, got);
    chk(got, "R3 self refresh entered", cke, 0);
    tick();
    noise = 1;
    for (int i = 0; i < 12; i++) begin
      noise_val = 2'($urandom); ref_req = 1'($urandom); pd_req = 1'($urandom);
      tick();
    end
    noise = 0; ref_req = 0; pd_req = 0;
    tick();
    sr_req = 0;
    wait_ack(500, got);
    chk(got, "R6 self-refresh exit acknowledged", got, 1);
    refs = 0;
    for (int i = 0; i < 3 * T_RFC; i++) begin
      tick();
      if ({cs_n, ras_n, cas_n, we_n} != f_enc(0) || busy) refs++;
    end
    chk(refs == 0, "R4 inputs in self refresh ignored", refs, 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      n = $urandom % 10;
      if (!busy && !pd_req && ($urandom % 3 == 0)) set_banks(2'($urandom));
      if (n < 3) begin
        ref_req = 1; tick(); ref_req = 0;
      end else if (n == 3) begin
        pd_req = ~pd_req; tick();
      end else if (n == 4 && ($urandom % 4 == 0)) begin
        sr_req = 1;
        repeat (5 + $urandom % 150) tick();
        sr_req = 0; tick();
      end else begin
        repeat (1 + $urandom % 6) tick();
      end
    end
    pd_req = 0; sr_req = 0;
    wait_idle(1000);
    repeat (3 * T_RFC) tick();
    chk(!busy && cke, "R11 idle at end", busy, 0);
    finish_run();
  end
endmodule